// File: doc/BRIEF.md
# Flash User-Test Sequencer

This block sits beside an embedded flash array and lets software run built-in test reads on it through a small 32-bit register bus. Test mode is closed after reset. A single fixed password, written to the control register, opens it. Software then chooses one of three runs: a plain integrity scan, a margin scan against either the zeros or the ones level, or an ECC logic check. Setting the start bit launches the run. Software polls the done bit until the run finishes.

Each run folds the data it reads into a 160-bit signature register, and software reads that register back as five 32-bit words. The scans visit every page of the sectors chosen by a sector mask, in ascending order. Each read waits a fixed number of extra cycles before its data is sampled. The ECC check touches no array page. Instead it pushes a forced 64-bit word and a forced 8-bit syndrome through the compaction path a fixed number of times.

While a run is in progress, the operand registers, the signature words and the mode fields are locked. Clearing start early aborts the run.

Top module: `flash_utest_ctrl`

## Requirements
- R1: After reset, done is 1, test mode is closed, the control register reads 0x00000001, every signature word reads 0, and arr_req is 0.
- R2: While test mode is closed, only a write of 0xF9F99999 to address 0 has an effect. That write sets bit 31 and nothing else. All other writes to any address are ignored. Writing the password when the mode is already open also changes nothing.
- R3: The control register at address 0 has these fields: bit 0 done (read-only), bit 1 start, bit 2 integrity select, bit 3 ECC-check enable, bit 4 margin-versus-ones, bit 5 margin enable, bits 15:8 forced syndrome, bit 31 mode enable. All other bits read 0. While the mode is open, a write updates these fields, and a write of zero clears them.
- R4: A write that takes start from 0 to 1 while done is 1 clears the signature and pulls done low at that edge. Done returns high when the run ends. The run type is chosen by priority: ECC check if bit 3 is set, otherwise margin if bit 5 is set, otherwise integrity.
- R5: A scan reads page addresses s*4+k for every sector s whose bit is set in the mask at address 3, going in ascending order. For each page, arr_req is held and arr_addr stays stable for WAIT_ST+1 cycles (3 by default), and the data is sampled in the last of those cycles.
- R6: For each sampled page, the signature becomes {m[158:0], m[159]^m[158]^m[141]^m[140]} XOR {16'b0, arr_chk[15:0], arr_data[127:0]}. Word i, at address 4+i, holds bits 32i+31 down to 32i.
- R7: An ECC-check run raises no arr_req. It performs exactly 8 steps of the R6 update, each with data {DHI, DLO, DHI, DLO} (DLO at address 1, DHI at address 2) and check bits {syn, syn}.
- R8: arr_lvl is 2'b10 during a margin run with bit 4 clear, 2'b11 during a margin run with bit 4 set, and 2'b00 at all other times.
- R9: If start is written to 0 while done is 0, the run stops. Done is 1 and arr_req is 0 after the next clock edge.
- R10: While done is 0, reads of addresses 1, 2 and 4 to 8 return 0. Writes to addresses 1 and 2 are ignored, and so are writes to control bits 2 to 5 and 15:8.
- R11: The sector mask is captured at launch. A mask write during a run does not change which pages that run reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; read data is 0 when low |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| arr_addr | output | 4 | Page address to the array |
| arr_req | output | 1 | Array read request |
| arr_lvl | output | 2 | Sense level for the read: 00 normal, 10 margin vs zeros, 11 margin vs ones |
| arr_data | input | 128 | Two 64-bit double words of the addressed page |
| arr_chk | input | 16 | Two 8-bit check-bit fields of the page |

## Verification
The hardest situations to reach are those in which software acts while a run is still going: an abort, a write to a locked operand or mode field, and a sector-mask change in mid-scan. Each of these needs bus writes to land inside the busy window. The bench makes that window long by scanning all four sectors, which takes 48 read cycles. It then issues its writes right after launch and checks that done rises at the expected edge. It also checks that the locked values come back unchanged once the run completes, and that the request count matches the mask captured at launch.

// File: rtl/ftc_pkg.sv
package ftc_pkg;

    localparam logic [31:0] UNLOCK_KEY = 32'hF9F99999;
    localparam int WORD_W       = 32;
    localparam int SIG_W        = 160;
    localparam int STEP_W       = 144;
    localparam int N_SIG_WORDS  = SIG_W / WORD_W;

    localparam int A_CTRL = 0;
    localparam int A_DLO  = 1;
    localparam int A_DHI  = 2;
    localparam int A_MASK = 3;
    localparam int A_SIG0 = 4;

    typedef enum logic [1:0] {OP_INTEG, OP_MARGIN, OP_ECC} op_e;
    typedef enum logic {ST_IDLE, ST_SCAN} seq_st_e;

    typedef struct packed {
        logic       en;
        logic [7:0] syn;
        logic       mre;
        logic       mrv;
        logic       eie;
        logic       ais;
        logic       start;
    } ctrl_t;

    function automatic op_e pick_op(input ctrl_t c);
        if (c.eie) return OP_ECC;
        if (c.mre) return OP_MARGIN;
        return OP_INTEG;
    endfunction

    function automatic logic [SIG_W-1:0] sig_next(input logic [SIG_W-1:0] m,
                                                  input logic [STEP_W-1:0] d);
        logic fb;
        fb = m[159] ^ m[158] ^ m[141] ^ m[140];
        return {m[SIG_W-2:0], fb} ^ {{(SIG_W-STEP_W){1'b0}}, d};
    endfunction

endpackage

// File: rtl/ftc_regs.sv
module ftc_regs import ftc_pkg::*; #(
    parameter int NUM_SECT = 4,
    parameter int ADDR_W   = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr,
    input  logic                 rd,
    input  logic [WORD_W-1:0]    wdata,
    output logic [WORD_W-1:0]    rdata,
    input  logic                 done,
    input  logic [SIG_W-1:0]     sig,
    output ctrl_t                ctrl,
    output logic [WORD_W-1:0]    dlo,
    output logic [WORD_W-1:0]    dhi,
    output logic [NUM_SECT-1:0]  mask,
    output logic                 launch
);

    logic wr_ctrl, is_key;

    assign wr_ctrl = wr && (addr == ADDR_W'(A_CTRL));
    assign is_key  = (wdata == UNLOCK_KEY);
    assign launch  = wr_ctrl && ctrl.en && !is_key && wdata[31] && wdata[1]
                     && !ctrl.start && done;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            dlo  <= '0;
            dhi  <= '0;
            mask <= '0;
        end else if (wr) begin
            if (wr_ctrl && is_key) begin
                ctrl.en <= 1'b1;
            end else if (ctrl.en) begin
                case (addr)
                    ADDR_W'(A_CTRL): begin
                        ctrl.en    <= wdata[31];
                        ctrl.start <= wdata[1];
                        if (done) begin
                            ctrl.ais <= wdata[2];
                            ctrl.eie <= wdata[3];
                            ctrl.mrv <= wdata[4];
                            ctrl.mre <= wdata[5];
                            ctrl.syn <= wdata[15:8];
                        end
                    end
                    ADDR_W'(A_DLO):  if (done) dlo <= wdata;
                    ADDR_W'(A_DHI):  if (done) dhi <= wdata;
                    ADDR_W'(A_MASK): mask <= wdata[NUM_SECT-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (rd) begin
            if (addr == ADDR_W'(A_CTRL))
                rdata = {ctrl.en, 15'b0, ctrl.syn, 2'b0, ctrl.mre, ctrl.mrv,
                         ctrl.eie, ctrl.ais, ctrl.start, done};
            if (done && addr == ADDR_W'(A_DLO))  rdata = dlo;
            if (done && addr == ADDR_W'(A_DHI))  rdata = dhi;
            if (addr == ADDR_W'(A_MASK))         rdata = WORD_W'(mask);
            for (int i = 0; i < N_SIG_WORDS; i++)
                if (done && addr == ADDR_W'(A_SIG0 + i))
                    rdata = sig[i*WORD_W +: WORD_W];
        end
    end

    AST_CLOSED_IGNORES: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !ctrl.en && !is_key) |=> !ctrl.en); // R2
    AST_DLO_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == ADDR_W'(A_DLO) && !done) |=> $stable(dlo)); // R10
    AST_FIELDS_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !done) |=> ($stable(ctrl.syn) && $stable(ctrl.eie) && $stable(ctrl.mre))); // R10

endmodule

// File: rtl/ftc_sig.sv
module ftc_sig import ftc_pkg::*; (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               step,
    input  logic [STEP_W-1:0]  din,
    output logic [SIG_W-1:0]   sig
);

    always_ff @(posedge clk) begin
        if (rst || clr)  sig <= '0;
        else if (step)   sig <= sig_next(sig, din);
    end

    AST_SIG_CLEARED: assert property (@(posedge clk) disable iff (rst)
        clr |=> (sig == '0)); // R4
    AST_SIG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!clr && !step) |=> $stable(sig)); // R6

endmodule

// File: rtl/ftc_seq.sv
module ftc_seq import ftc_pkg::*; #(
    parameter int NUM_SECT       = 4,
    parameter int PAGES_PER_SECT = 4,
    parameter int WAIT_ST        = 2,
    parameter int ECC_STEPS      = 8,
    localparam int NPAGES = NUM_SECT * PAGES_PER_SECT,
    localparam int PAW    = $clog2(NPAGES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 launch,
    input  logic                 start,
    input  op_e                  op,
    input  logic                 mrv,
    input  logic [NUM_SECT-1:0]  mask_in,
    input  logic [WORD_W-1:0]    dlo,
    input  logic [WORD_W-1:0]    dhi,
    input  logic [7:0]           syn,
    input  logic [127:0]         arr_data,
    input  logic [15:0]          arr_chk,
    output logic [PAW-1:0]       arr_addr,
    output logic                 arr_req,
    output logic [1:0]           arr_lvl,
    output logic                 done,
    output logic                 sig_step,
    output logic [STEP_W-1:0]    step_data
);

    localparam int SBITS = $clog2(PAGES_PER_SECT);
    localparam int SW    = $clog2(NUM_SECT);
    localparam int WSW   = $clog2(WAIT_ST + 2);
    localparam int ECW   = $clog2(ECC_STEPS + 1);

    seq_st_e              state;
    op_e                  op_q;
    logic                 mrv_q;
    logic [NUM_SECT-1:0]  mask_q;
    logic [PAW-1:0]       pg;
    logic [WSW-1:0]       ws;
    logic [ECW-1:0]       ecnt;
    logic [SW-1:0]        sect_idx;
    logic                 running, scan_mode, page_on, ecc_step, sample;

    assign running   = (state == ST_SCAN);
    assign scan_mode = (op_q != OP_ECC);
    assign sect_idx  = SW'(pg >> SBITS);
    assign page_on   = mask_q[sect_idx];
    assign arr_req   = running && scan_mode && start && page_on;
    assign arr_addr  = pg;
    assign arr_lvl   = (running && op_q == OP_MARGIN) ? {1'b1, mrv_q} : 2'b00;
    assign sample    = arr_req && (ws == WSW'(WAIT_ST));
    assign ecc_step  = running && !scan_mode && start;
    assign sig_step  = sample || ecc_step;
    assign step_data = scan_mode ? {arr_chk, arr_data}
                                 : {syn, syn, dhi, dlo, dhi, dlo};

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            done   <= 1'b1;
            op_q   <= OP_INTEG;
            mrv_q  <= 1'b0;
            mask_q <= '0;
            pg     <= '0;
            ws     <= '0;
            ecnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (launch) begin
                    state  <= ST_SCAN;
                    done   <= 1'b0;
                    op_q   <= op;
                    mrv_q  <= mrv;
                    mask_q <= mask_in;
                    pg     <= '0;
                    ws     <= '0;
                    ecnt   <= '0;
                end
                ST_SCAN: begin
                    if (!start) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else if (!scan_mode) begin
                        ecnt <= ecnt + 1'b1;
                        if (ecnt == ECW'(ECC_STEPS - 1)) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end
                    end else if (page_on && ws != WSW'(WAIT_ST)) begin
                        ws <= ws + 1'b1;
                    end else begin
                        ws <= '0;
                        if (pg == PAW'(NPAGES - 1)) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            pg <= pg + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (rst)
        launch |=> !done); // R4
    AST_ABORT_QUICK: assert property (@(posedge clk) disable iff (rst)
        (running && !start) |=> (done && !arr_req)); // R9
    AST_ECC_NO_READ: assert property (@(posedge clk) disable iff (rst)
        (running && op_q == OP_ECC) |-> !arr_req); // R7
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (arr_req && ws != '0) |-> $stable(arr_addr)); // R5
    AST_LVL_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> (arr_lvl == 2'b00)); // R8

endmodule

// File: rtl/flash_utest_ctrl.sv
module flash_utest_ctrl import ftc_pkg::*; #(
    parameter int NUM_SECT       = 4,
    parameter int PAGES_PER_SECT = 4,
    parameter int WAIT_ST        = 2,
    parameter int ECC_STEPS      = 8,
    parameter int ADDR_W         = 4,
    localparam int PAW = $clog2(NUM_SECT * PAGES_PER_SECT)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic [PAW-1:0]      arr_addr,
    output logic                arr_req,
    output logic [1:0]          arr_lvl,
    input  logic [127:0]        arr_data,
    input  logic [15:0]         arr_chk
);

    ctrl_t                ctrl;
    logic [WORD_W-1:0]    dlo, dhi;
    logic [NUM_SECT-1:0]  mask;
    logic                 launch, done, sig_step;
    logic [STEP_W-1:0]    step_data;
    logic [SIG_W-1:0]     sig;

    ftc_regs #(.NUM_SECT(NUM_SECT), .ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst(rst), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
        .wdata(reg_wdata), .rdata(reg_rdata), .done(done), .sig(sig),
        .ctrl(ctrl), .dlo(dlo), .dhi(dhi), .mask(mask), .launch(launch)
    );

    ftc_seq #(.NUM_SECT(NUM_SECT), .PAGES_PER_SECT(PAGES_PER_SECT),
              .WAIT_ST(WAIT_ST), .ECC_STEPS(ECC_STEPS)) seq_i (
        .clk(clk), .rst(rst), .launch(launch), .start(ctrl.start),
        .op(pick_op(ctrl)), .mrv(ctrl.mrv), .mask_in(mask), .dlo(dlo),
        .dhi(dhi), .syn(ctrl.syn), .arr_data(arr_data), .arr_chk(arr_chk),
        .arr_addr(arr_addr), .arr_req(arr_req), .arr_lvl(arr_lvl),
        .done(done), .sig_step(sig_step), .step_data(step_data)
    );

    ftc_sig sig_i (
        .clk(clk), .rst(rst), .clr(launch), .step(sig_step),
        .din(step_data), .sig(sig)
    );

endmodule

// File: tb/flash_utest_ctrl_tb_top.sv
module flash_utest_ctrl_tb_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   reg_addr = '0;
    logic         reg_wr = 1'b0;
    logic         reg_rd = 1'b0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic [3:0]   arr_addr;
    logic         arr_req;
    logic [1:0]   arr_lvl;
    logic [127:0] arr_data;
    logic [15:0]  arr_chk;

    int n_total = 0;
    int n_fail  = 0;
    int req_cnt = 0;
    bit order_bad = 1'b0;
    bit have_last = 1'b0;
    logic [3:0] last_addr = '0;
    logic [31:0] rv;

    always #4 clk = ~clk;

    flash_utest_ctrl dut_i (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .arr_addr(arr_addr), .arr_req(arr_req), .arr_lvl(arr_lvl),
        .arr_data(arr_data), .arr_chk(arr_chk)
    );

    function automatic logic [127:0] mdat(input logic [3:0] p);
        logic [31:0] q;
        q = {28'h0, p};
        return {q * 32'h11111111 ^ 32'hDEADBEEF, 32'h0F0F0000 | q,
                32'hA5A50000 + q * 3, ~q};
    endfunction

    function automatic logic [15:0] mchk(input logic [3:0] p);
        return {8'h3C ^ {4'h0, p}, 8'hC3 + {4'h0, p}};
    endfunction

    assign arr_data = mdat(arr_addr);
    assign arr_chk  = mchk(arr_addr);

    function automatic logic [159:0] bstep(input logic [159:0] m, input logic [143:0] d);
        return {m[158:0], m[159] ^ m[158] ^ m[141] ^ m[140]} ^ {16'h0, d};
    endfunction

    // mode: 0 integrity, 1 margin vs zeros, 2 margin vs ones, 3 ECC check
    function automatic logic [159:0] exp_sig(input int mode, input logic [3:0] mask,
            input logic [31:0] dlo, input logic [31:0] dhi, input logic [7:0] syn);
        logic [159:0] m;
        m = '0;
        if (mode == 3) begin
            for (int k = 0; k < 8; k++) m = bstep(m, {syn, syn, dhi, dlo, dhi, dlo});
        end else begin
            for (int p = 0; p < 16; p++)
                if (mask[p / 4]) m = bstep(m, {mchk(4'(p)), mdat(4'(p))});
        end
        return m;
    endfunction

    function automatic logic [31:0] mode_bits(input int mode);
        case (mode)
            1: return 32'h24;
            2: return 32'h34;
            3: return 32'h08;
            default: return 32'h04;
        endcase
    endfunction

    always @(negedge clk) begin
        if (arr_req) begin
            if (have_last && arr_addr < last_addr) order_bad = 1'b1;
            last_addr = arr_addr;
            have_last = 1'b1;
            req_cnt++;
        end
    end

    task automatic check(input string tag, input logic [159:0] act, input logic [159:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = 4'(a); reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 4'(a); reg_rd = 1'b1;
        #1 d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        logic [31:0] c;
        c = '0;
        for (int i = 0; i < 1000 && !c[0]; i++) rd(0, c);
        check(tag, {159'h0, c[0]}, 160'h1);
    endtask

    task automatic clear_mon();
        req_cnt = 0; order_bad = 1'b0; have_last = 1'b0;
    endtask

    // {mask[3:0], mode[1:0], syn[7:0], dhi[31:0], dlo[31:0]}
    localparam logic [77:0] VECS [7] = '{
        {4'hF, 2'd0, 8'h00, 32'h0, 32'h0},
        {4'h5, 2'd1, 8'h00, 32'h0, 32'h0},
        {4'hA, 2'd2, 8'h00, 32'h0, 32'h0},
        {4'h0, 2'd3, 8'h5A, 32'h9ABCDEF0, 32'h12345678},
        {4'h0, 2'd0, 8'h00, 32'h0, 32'h0},
        {4'h8, 2'd0, 8'h00, 32'h0, 32'h0},
        {4'h0, 2'd3, 8'h00, 32'h0, 32'h0}
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_total++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(0, rv); check("R1 ctrl", {128'h0, rv}, {128'h0, 32'h00000001});
        rd(4, rv); check("R1 sig0", {128'h0, rv}, 160'h0);
        rd(8, rv); check("R1 sig4", {128'h0, rv}, 160'h0);
        check("R1 arr_req", {159'h0, arr_req}, 160'h0);

        // R2 closed mode ignores everything but the key
        wr(1, 32'h00001234);
        wr(0, 32'h80000006);
        rd(0, rv); check("R2 ctrl closed", {128'h0, rv}, {128'h0, 32'h00000001});
        rd(1, rv); check("R2 dlo closed", {128'h0, rv}, 160'h0);
        wr(0, 32'hF9F99999);
        rd(0, rv); check("R2 key opens", {128'h0, rv}, {128'h0, 32'h80000001});

        // R3 field layout, key rewrite, zero write
        wr(0, 32'h8000A53C);
        rd(0, rv); check("R3 fields", {128'h0, rv}, {128'h0, 32'h8000A53D});
        wr(0, 32'hF9F99999);
        rd(0, rv); check("R2 key no change", {128'h0, rv}, {128'h0, 32'h8000A53D});
        wr(0, 32'h0);
        rd(0, rv); check("R3 zero clears", {128'h0, rv}, {128'h0, 32'h00000001});
        wr(0, 32'hF9F99999);

        // R4 R5 R6 R7 R8 vector runs
        for (int v = 0; v < 7; v++) begin
            logic [3:0]  vm;
            int          vmode;
            logic [7:0]  vs;
            logic [31:0] vh, vl, cw;
            logic [159:0] es;
            logic [1:0]  el;
            vm = VECS[v][77:74]; vmode = int'(VECS[v][73:72]); vs = VECS[v][71:64];
            vh = VECS[v][63:32]; vl = VECS[v][31:0];
            cw = 32'h80000000 | mode_bits(vmode) | {16'h0, vs, 8'h0};
            el = (vmode == 1) ? 2'b10 : (vmode == 2) ? 2'b11 : 2'b00;
            wr(1, vl); wr(2, vh); wr(3, {28'h0, vm}); wr(0, cw);
            clear_mon();
            wr(0, cw | 32'h2);
            check("R8 lvl", {158'h0, arr_lvl}, {158'h0, el});
            rd(0, rv); check("R4 done low", {159'h0, rv[0]}, 160'h0);
            rd(4, rv); check("R10 sig hidden", {128'h0, rv}, 160'h0);
            wait_done("R4 done rises");
            es = exp_sig(vmode, vm, vl, vh, vs);
            for (int w = 0; w < 5; w++) begin
                rd(4 + w, rv);
                check((vmode == 3) ? "R7 ecc sig" : "R6 scan sig", {128'h0, rv}, {128'h0, es[w*32 +: 32]});
            end
            check((vmode == 3) ? "R7 no reads" : "R5 read cycles", 160'(req_cnt),
                  160'((vmode == 3) ? 0 : $countones(vm) * 4 * 3));
            check("R5 ascending", {159'h0, order_bad}, 160'h0);
            wr(0, cw);
        end

        // R9 abort mid-run
        wr(1, 32'h0000BEEF); wr(3, 32'hF); wr(0, 32'h80000004);
        wr(0, 32'h80000006);
        repeat (5) @(negedge clk);
        wr(0, 32'h80000004);
        rd(0, rv);
        check("R9 done after abort", {159'h0, rv[0]}, 160'h1);
        check("R9 req low", {159'h0, arr_req}, 160'h0);

        // R10 R11 locking during a run
        wr(3, 32'h1);
        clear_mon();
        wr(0, 32'h80000006);
        wr(3, 32'hF);
        wr(1, 32'hDEAD0000);
        wr(0, 32'h8000FF3E);
        rd(0, rv); check("R10 fields locked", {128'h0, rv}, {128'h0, 32'h80000006});
        rd(1, rv); check("R10 dlo hidden", {128'h0, rv}, 160'h0);
        wait_done("R10 done");
        rd(1, rv); check("R10 dlo kept", {128'h0, rv}, {128'h0, 32'h0000BEEF});
        check("R11 mask frozen", 160'(req_cnt), 160'd12);
        wr(0, 32'h80000004);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule